// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block sits above a single-shot AUX transaction engine and turns one request into a bounded series of attempts. For each attempt it pulses `eng_start` and waits for `eng_done`. It then receives a result class and a 4-bit reply code. From these it decides whether to finish with pass, finish with fail, retry at once, or wait a programmed number of milliseconds before the next attempt. The millisecond wait is built from a microsecond tick input.

Each cause of retry has its own budget. A successful attempt resets the timeout and invalid-reply budgets. Defers are limited by a count and by the total defer time. Once an I2C link-side defer has been seen in a transaction, a later timeout is treated as a defer.

The control is a six-state machine:
- S_IDLE goes to S_ISSUE on an accepted request.
- S_ISSUE goes to S_WAIT_ENG after one cycle.
- S_WAIT_ENG goes to S_DECIDE on `eng_done`.
- S_DECIDE goes to S_DONE on pass or fail, to S_ISSUE on an immediate retry, and to S_PAUSE on a delayed retry.
- S_PAUSE goes to S_ISSUE when the millisecond timer runs out.
- S_DONE goes back to S_IDLE after one cycle.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A request (`req_valid`) is accepted only in S_IDLE. A request raised while `busy` is high has no effect: neither the running transaction nor the idle state after it is changed.
- R2: Every attempt is one single-cycle `eng_start` pulse. Result codes are: 0 success, 1 timeout, 2 invalid reply, 3 HPD disconnect, 4 acquire failure. Reply codes are: 0x0 ACK, 0x1 native NACK, 0x2 native defer, 0x8 I2C link-side defer, 0xA I2C sink defer. The end of a transaction is a one-cycle `done` pulse, with `pass` and `last_reply` holding the final attempt's outcome. Success with ACK and enough bytes ends with pass.
- R3: A transaction makes at most 7 attempts. An attempt that would otherwise retry fails once 7 attempts have been made.
- R4: On a read, success with ACK but fewer reply bytes (`eng_bytes`) than `req_len` is retried at once.
- R5: An invalid-reply result fails the transaction on its 2nd occurrence. A success result clears the invalid-reply and timeout counts.
- R6: With no earlier link-side defer, a timeout result is retried with no wait and fails on its 3rd occurrence.
- R7: A native or link-side defer waits `req_defer_ms` milliseconds (1000 ticks each; 0 means no wait) before the retry. The delay is added to a running total. The defer gives up only when at least 7 defers are counted and the total has reached 50 ms.
- R8: After a link-side defer (0x8), a timeout is counted as a defer, up to a limit of 7, and waits the defer delay instead of using the timeout budget.
- R9: A sink defer (0xA) is retried at once, fails on its 7th occurrence, and clears the defer count.
- R10: A native NACK, an HPD-disconnect result, an acquire failure, or any unlisted reply code ends the transaction at once with fail.
- R11: After reset the block is idle: `busy`, `done` and `eng_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Start a transaction |
| req_read | input | 1 | Transaction is a read |
| req_len | input | 8 | Requested byte count |
| req_defer_ms | input | 8 | Defer delay in milliseconds |
| eng_start | output | 1 | Start one engine attempt |
| eng_done | input | 1 | Engine attempt finished |
| eng_result | input | 3 | Engine result class |
| eng_reply | input | 4 | Reply code of the attempt |
| eng_bytes | input | 8 | Data bytes returned by the attempt |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pass | output | 1 | Final outcome, valid with `done` |
| last_reply | output | 4 | Reply code of the final attempt |

## Verification
The assertions assume that the engine raises `eng_done` only once per `eng_start`, and only after it. They also assume that `us_tick` is a clean pulse. The bench's engine model answers each start pulse exactly once, two cycles later, and drives the tick high on every cycle. All stimulus changes on the falling clock edge, so the start-count and pulse-width properties see well-formed traffic.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT_ENG,
        S_DECIDE,
        S_PAUSE,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_PASS,
        ACT_FAIL,
        ACT_NOW,
        ACT_WAIT
    } act_e;

    localparam logic [2:0] RES_OK      = 3'd0;
    localparam logic [2:0] RES_TIMEOUT = 3'd1;
    localparam logic [2:0] RES_INVALID = 3'd2;
    localparam logic [2:0] RES_HPD     = 3'd3;
    localparam logic [2:0] RES_ACQUIRE = 3'd4;

    localparam logic [3:0] RPL_ACK        = 4'h0;
    localparam logic [3:0] RPL_NACK       = 4'h1;
    localparam logic [3:0] RPL_AUX_DEFER  = 4'h2;
    localparam logic [3:0] RPL_LINK_DEFER = 4'h8;
    localparam logic [3:0] RPL_SINK_DEFER = 4'hA;

endpackage

// File: rtl/aux_ms_timer.sv
module aux_ms_timer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int MSW          = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [MSW-1:0] ms_i,
    input  logic           us_tick,
    output logic           expired_o
);
    localparam int TW = $clog2(TICKS_PER_MS + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_MS - 1);

    logic [MSW-1:0] ms_left_q;
    logic [TW-1:0]  tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_left_q <= '0;
            tick_q    <= '0;
        end else if (load_i) begin
            ms_left_q <= ms_i;
            tick_q    <= '0;
        end else if (us_tick && ms_left_q != '0) begin
            if (tick_q == TICK_LAST) begin
                tick_q    <= '0;
                ms_left_q <= ms_left_q - 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign expired_o = (ms_left_q == '0);
endmodule

// File: rtl/aux_retry_budget.sv
module aux_retry_budget
    import aux_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS     = 7,
    parameter int INVALID_LIMIT    = 2,
    parameter int TIMEOUT_LIMIT    = 3,
    parameter int DEFER_MIN        = 7,
    parameter int SINK_DEFER_LIMIT = 7,
    parameter int DEFER_CAP_MS     = 50,
    parameter int MSW              = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           issue_i,
    input  logic           step_i,
    input  logic [2:0]     res_i,
    input  logic [3:0]     reply_i,
    input  logic           short_i,
    input  logic [MSW-1:0] ms_i,
    output act_e           act_o
);
    localparam int CW = $clog2(MAX_ATTEMPTS + DEFER_MIN + SINK_DEFER_LIMIT + 1) + 1;
    localparam int DW = 16;
    localparam logic [CW-1:0] ATT_LIM  = CW'(MAX_ATTEMPTS);
    localparam logic [CW-1:0] INV_LIM  = CW'(INVALID_LIMIT);
    localparam logic [CW-1:0] TMO_LIM  = CW'(TIMEOUT_LIMIT);
    localparam logic [CW-1:0] DFR_LIM  = CW'(DEFER_MIN);
    localparam logic [CW-1:0] SINK_LIM = CW'(SINK_DEFER_LIMIT);
    localparam logic [DW-1:0] CAP      = DW'(DEFER_CAP_MS);

    logic [CW-1:0] att_q, inv_q, tmo_q, dfr_q, sink_q;
    logic [CW-1:0] inv_n, tmo_n, dfr_n, sink_n;
    logic [DW-1:0] dtime_q;
    logic [DW:0]   dtime_sum;
    logic          seen_q;
    act_e          base;

    assign inv_n     = inv_q + 1'b1;
    assign tmo_n     = tmo_q + 1'b1;
    assign dfr_n     = dfr_q + 1'b1;
    assign sink_n    = sink_q + 1'b1;
    assign dtime_sum = {1'b0, dtime_q} + (DW+1)'(ms_i);

    always_comb begin
        base = ACT_FAIL;
        case (res_i)
            RES_OK: begin
                case (reply_i)
                    RPL_ACK:        base = short_i ? ACT_NOW : ACT_PASS;
                    RPL_AUX_DEFER,
                    RPL_LINK_DEFER: base = (dfr_n >= DFR_LIM && dtime_q >= CAP) ? ACT_FAIL : ACT_WAIT;
                    RPL_SINK_DEFER: base = (sink_n >= SINK_LIM) ? ACT_FAIL : ACT_NOW;
                    default:        base = ACT_FAIL;
                endcase
            end
            RES_TIMEOUT: begin
                if (seen_q) base = (dfr_n >= DFR_LIM) ? ACT_FAIL : ACT_WAIT;
                else        base = (tmo_n >= TMO_LIM) ? ACT_FAIL : ACT_NOW;
            end
            RES_INVALID: base = (inv_n >= INV_LIM) ? ACT_FAIL : ACT_NOW;
            default:     base = ACT_FAIL;
        endcase
        if ((base == ACT_NOW || base == ACT_WAIT) && att_q >= ATT_LIM) act_o = ACT_FAIL;
        else act_o = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q <= '0; inv_q <= '0; tmo_q <= '0; dfr_q <= '0; sink_q <= '0;
            dtime_q <= '0; seen_q <= 1'b0;
        end else if (clear_i) begin
            att_q <= '0; inv_q <= '0; tmo_q <= '0; dfr_q <= '0; sink_q <= '0;
            dtime_q <= '0; seen_q <= 1'b0;
        end else begin
            if (issue_i) att_q <= att_q + 1'b1;
            if (step_i) begin
                case (res_i)
                    RES_OK: begin
                        inv_q <= '0;
                        tmo_q <= '0;
                        if (reply_i == RPL_AUX_DEFER || reply_i == RPL_LINK_DEFER) begin
                            dfr_q   <= dfr_n;
                            dtime_q <= dtime_sum[DW] ? '1 : dtime_sum[DW-1:0];
                            if (reply_i == RPL_LINK_DEFER) seen_q <= 1'b1;
                        end else if (reply_i == RPL_SINK_DEFER) begin
                            dfr_q  <= '0;
                            sink_q <= sink_n;
                        end
                    end
                    RES_TIMEOUT: begin
                        if (seen_q) dfr_q <= dfr_n;
                        else        tmo_q <= tmo_n;
                    end
                    RES_INVALID: inv_q <= inv_n;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 7,
    parameter int TICKS_PER_MS = 1000,
    parameter int MSW          = 8,
    parameter int LW           = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           us_tick,
    input  logic           req_valid,
    input  logic           req_read,
    input  logic [LW-1:0]  req_len,
    input  logic [MSW-1:0] req_defer_ms,
    output logic           eng_start,
    input  logic           eng_done,
    input  logic [2:0]     eng_result,
    input  logic [3:0]     eng_reply,
    input  logic [LW-1:0]  eng_bytes,
    output logic           busy,
    output logic           done,
    output logic           pass,
    output logic [3:0]     last_reply
);
    seq_state_e     state_q, state_d;
    act_e           act;
    logic           accept;
    logic           rd_q;
    logic [LW-1:0]  len_q, bytes_q;
    logic [MSW-1:0] ms_q;
    logic [2:0]     res_q;
    logic [3:0]     rep_q;
    logic           timer_expired;
    logic           short_rd;

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign short_rd = rd_q && (bytes_q < len_q);

    aux_retry_budget #(
        .MAX_ATTEMPTS (MAX_ATTEMPTS),
        .MSW          (MSW)
    ) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .issue_i (state_q == S_ISSUE),
        .step_i  (state_q == S_DECIDE),
        .res_i   (res_q),
        .reply_i (rep_q),
        .short_i (short_rd),
        .ms_i    (ms_q),
        .act_o   (act)
    );

    aux_ms_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MSW          (MSW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (state_q == S_DECIDE && act == ACT_WAIT),
        .ms_i      (ms_q),
        .us_tick   (us_tick),
        .expired_o (timer_expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_ISSUE;
            S_ISSUE:    state_d = S_WAIT_ENG;
            S_WAIT_ENG: if (eng_done) state_d = S_DECIDE;
            S_DECIDE: begin
                unique case (act)
                    ACT_PASS, ACT_FAIL: state_d = S_DONE;
                    ACT_NOW:            state_d = S_ISSUE;
                    ACT_WAIT:           state_d = S_PAUSE;
                endcase
            end
            S_PAUSE:    if (timer_expired) state_d = S_ISSUE;
            S_DONE:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0; len_q <= '0; ms_q <= '0;
            res_q <= '0; rep_q <= '0; bytes_q <= '0;
            pass <= 1'b0; last_reply <= '0;
        end else begin
            if (accept) begin
                rd_q  <= req_read;
                len_q <= req_len;
                ms_q  <= req_defer_ms;
            end
            if (state_q == S_WAIT_ENG && eng_done) begin
                res_q   <= eng_result;
                rep_q   <= eng_reply;
                bytes_q <= eng_bytes;
            end
            if (state_q == S_DECIDE && (act == ACT_PASS || act == ACT_FAIL)) begin
                pass       <= (act == ACT_PASS);
                last_reply <= rep_q;
            end
        end
    end

    always_comb begin
        eng_start = (state_q == S_ISSUE);
        done      = (state_q == S_DONE);
        busy      = (state_q != S_IDLE);
    end
endmodule

module aux_retry_ctrl_chk #(
    parameter int MAX_ATTEMPTS = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       eng_start,
    input logic       busy,
    input logic       done,
    input logic       pass,
    input logic [3:0] last_reply
);
    logic [7:0] starts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  starts_q <= '0;
        else if (!busy && req_valid) starts_q <= '0;
        else if (eng_start)          starts_q <= starts_q + 1'b1;
    end

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R2
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    pass_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (last_reply == 4'h0));

    // R3
    attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (starts_q <= 8'(MAX_ATTEMPTS)));
endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .eng_start  (eng_start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .last_reply (last_reply)
);

// File: tb/aux_retry_ctrl_tb_top.sv
module aux_retry_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic [7:0] req_len = '0;
    logic [7:0] req_defer_ms = '0;
    logic       eng_start;
    logic       eng_done = 1'b0;
    logic [2:0] eng_result = '0;
    logic [3:0] eng_reply = '0;
    logic [7:0] eng_bytes = '0;
    logic       busy, done, pass;
    logic [3:0] last_reply;

    int errors = 0;
    int checks = 0;
    int n_start = 0;
    logic [2:0] rsp_res [8];
    logic [3:0] rsp_rep [8];
    logic [7:0] rsp_bytes [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_retry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .req_valid(req_valid), .req_read(req_read), .req_len(req_len),
        .req_defer_ms(req_defer_ms), .eng_start(eng_start), .eng_done(eng_done),
        .eng_result(eng_result), .eng_reply(eng_reply), .eng_bytes(eng_bytes),
        .busy(busy), .done(done), .pass(pass), .last_reply(last_reply)
    );

    // Engine model: answers each start pulse two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_start) begin
                int idx;
                idx = (n_start > 7) ? 7 : n_start;
                n_start++;
                @(negedge clk);
                @(negedge clk);
                eng_result = rsp_res[idx];
                eng_reply  = rsp_rep[idx];
                eng_bytes  = rsp_bytes[idx];
                eng_done   = 1'b1;
                @(negedge clk);
                eng_done   = 1'b0;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [2:0] res, input logic [3:0] rep, input logic [7:0] nb);
        for (int i = 0; i < 8; i++) begin
            rsp_res[i] = res; rsp_rep[i] = rep; rsp_bytes[i] = nb;
        end
    endtask

    task automatic run_txn(input logic rd, input logic [7:0] len, input logic [7:0] ms,
                           input logic exp_pass, input int exp_att, input logic [3:0] exp_rep,
                           input string tag, output int elapsed);
        n_start = 0;
        elapsed = 0;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_len = len; req_defer_ms = ms;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && elapsed < 20000) begin
            @(negedge clk);
            elapsed++;
        end
        chk(pass == exp_pass, {tag, " pass"}, int'(pass), int'(exp_pass));
        chk(n_start == exp_att, {tag, " attempts"}, n_start, exp_att);
        chk(last_reply == exp_rep, {tag, " reply"}, int'(last_reply), int'(exp_rep));
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !eng_start, "R11 idle after reset", int'(busy), 0);
    endtask

    task automatic t_basic;
        int el;
        fill(3'd0, 4'h0, 8'd4);
        run_txn(1'b0, 8'd4, 8'd0, 1'b1, 1, 4'h0, "R2 write ack", el);
        fill(3'd0, 4'h0, 8'd3);
        rsp_bytes[2] = 8'd4;
        run_txn(1'b1, 8'd4, 8'd0, 1'b1, 3, 4'h0, "R4 short read recovers", el);
        fill(3'd0, 4'h0, 8'd1);
        run_txn(1'b1, 8'd4, 8'd0, 1'b0, 7, 4'h0, "R3 attempt limit", el);
    endtask

    task automatic t_invalid;
        int el;
        fill(3'd2, 4'h0, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 2, 4'h0, "R5 invalid twice", el);
        fill(3'd0, 4'h0, 8'd2);
        rsp_res[0] = 3'd2; rsp_bytes[1] = 8'd0; rsp_res[2] = 3'd2;
        run_txn(1'b1, 8'd2, 8'd0, 1'b1, 4, 4'h0, "R5 success clears invalid", el);
    endtask

    task automatic t_timeout;
        int el;
        fill(3'd1, 4'h0, 8'd0);
        run_txn(1'b0, 8'd1, 8'd9, 1'b0, 3, 4'h0, "R6 timeout thrice", el);
        chk(el < 100, "R6 no wait on timeout", el, 100);
    endtask

    task automatic t_terminal;
        int el;
        fill(3'd0, 4'h1, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 1, 4'h1, "R10 native nack", el);
        fill(3'd3, 4'h0, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 1, 4'h0, "R10 hpd", el);
        fill(3'd4, 4'h0, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 1, 4'h0, "R10 acquire", el);
    endtask

    task automatic t_defer;
        int el;
        fill(3'd0, 4'h0, 8'd0);
        rsp_rep[0] = 4'h2;
        run_txn(1'b0, 8'd1, 8'd2, 1'b1, 2, 4'h0, "R7 defer then ack", el);
        chk(el >= 2000 && el < 2100, "R7 defer wait 2 ms", el, 2000);
        fill(3'd0, 4'h2, 8'd0);
        rsp_rep[6] = 4'h0;
        run_txn(1'b0, 8'd1, 8'd0, 1'b1, 7, 4'h0, "R7 six defers under cap", el);
        fill(3'd0, 4'h2, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 7, 4'h2, "R7 defers exhausted", el);
    endtask

    task automatic t_link_timeout;
        int el;
        fill(3'd0, 4'h0, 8'd0);
        rsp_rep[0] = 4'h8;
        rsp_res[1] = 3'd1; rsp_res[2] = 3'd1; rsp_res[3] = 3'd1;
        run_txn(1'b0, 8'd1, 8'd0, 1'b1, 5, 4'h0, "R8 timeout after link defer", el);
    endtask

    task automatic t_sink;
        int el;
        fill(3'd0, 4'hA, 8'd0);
        run_txn(1'b0, 8'd1, 8'd0, 1'b0, 7, 4'hA, "R9 sink defer limit", el);
        fill(3'd0, 4'h0, 8'd0);
        rsp_rep[0] = 4'hA;
        run_txn(1'b0, 8'd1, 8'd0, 1'b1, 2, 4'h0, "R9 sink defer retried", el);
    endtask

    task automatic t_ignore;
        int cyc;
        fill(3'd0, 4'h0, 8'd0);
        rsp_rep[0] = 4'h2;
        n_start = 0;
        @(negedge clk);
        req_valid = 1'b1; req_read = 1'b0; req_len = 8'd0; req_defer_ms = 8'd1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (200) @(negedge clk);
        req_valid = 1'b1; req_read = 1'b1; req_len = 8'd9; req_defer_ms = 8'd5;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(pass == 1'b1, "R1 busy request ignored pass", int'(pass), 1);
        chk(n_start == 2, "R1 busy request ignored attempts", n_start, 2);
        repeat (20) @(negedge clk);
        chk(!busy && n_start == 2, "R1 no transaction after busy request", n_start, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fill(3'd0, 4'h0, 8'd0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_invalid();
        t_timeout();
        t_terminal();
        t_defer();
        t_link_timeout();
        t_sink();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule